// File: doc/BRIEF.md
# BCD Clock Calendar with Alarm

This block is a time-of-day and calendar counter. It keeps hundredths of seconds, seconds, minutes, hours, day of month, month, weekday and a two-bit year, every field in packed BCD, and advances by one hundredth on each single-cycle pulse of a 100 Hz tick input. Rollover is carried up the whole chain. Month lengths follow the month value. Year 0 of the four-year cycle is the leap year. Hours run in either 24-hour or 12-hour format.

A simple register interface lets software write and read every counter, set the control bits and program the alarm registers. Reads are combinational from the address. Writes land on the next clock edge. An alarm flag is raised when the counters selected by the alarm mode equal the alarm registers. The flag stays set until software clears it.

Register map, one byte per address:
- 0: control. Bit 0 is stop. Bit 1 selects 12-hour mode. Bits 3:2 are the alarm mode.
- 1: hundredths.
- 2: seconds.
- 3: minutes.
- 4: hours.
- 5: year and day.
- 6: weekday and month.
- 8 to 11: alarm hundredths, seconds, minutes and hours.
- 12: alarm date.
- 13: alarm month.
- 14: alarm weekday mask.
- 15: alarm flag, in bit 0.

Top module: `rtc_cal_top`

## Requirements
- R1: After reset, hundredths, seconds, minutes and hours read 00. The year/day register (address 5) reads 0x01, which is year 0 and day 01. The weekday/month register (address 6) reads 0x01, which is weekday 0 and month 01. Control and the alarm flag read 0.
- R2: Hundredths, seconds and minutes are two BCD digits, with tens in bits 7:4 and units in bits 3:0. They wrap after 99, 59 and 59, and each wrap advances the next field on the same tick.
- R3: With control bit 1 clear, hours count 00 to 23. The wrap from 23 back to 00 advances the day.
- R4: With control bit 1 set, bit 6 of the hours register is a PM flag and bits 4:0 hold the hour in BCD.
  - The hour counts 12, 01, up to 11.
  - Passing from 11 to 12 toggles PM.
  - Passing from 11 PM to 12 AM advances the day.
- R5: The year/day register holds the year in bits 7:6 and the day in BCD in bits 5:0. Days count from 01.
  - Months 04, 06, 09 and 11 have 30 days.
  - Month 02 has 29 days in year 0 and 28 days in the other years.
  - All other months have 31 days.
  - After the last day, the day returns to 01 and the month advances.
- R6: The weekday/month register holds the weekday in bits 7:5 and the month in BCD in bits 4:0. After month 12 the month returns to 01 and the year increments modulo 4. The weekday increments modulo 7 at each day rollover.
- R7: While control bit 0 (stop) is set, ticks change no counter. Writes still take effect.
- R8: A write to a counter address replaces that counter on the next clock edge. It takes priority over a tick in the same cycle.
- R9: Alarm mode 01 (daily) compares hundredths, seconds, minutes and hours only.
- R10: Alarm mode 11 (dated) compares the time, the date in bits 5:0 against alarm date bits 5:0, and the month in bits 4:0 against alarm month bits 4:0. It ignores year and weekday.
- R11: Alarm mode 10 (weekday) requires the time to match and bit N of the alarm weekday mask to be set, where N is the current weekday.
- R12: The flag sets one clock after the selected comparison first becomes true. It then holds until a write of 0 to bit 0 of address 15. In alarm mode 00 the flag never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse at 100 Hz |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for reads and writes |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` |
| alarmFlag | output | 1 | Sticky alarm flag |

## Verification
The hardest states to reach from the ports are the end-of-period rollovers: 11 PM to 12 AM in 12-hour mode, the last day of February in leap and non-leap years, and the December-to-January year wrap. Each needs the full carry chain to ripple on a single tick. The bench reaches each one by writing the counters to one hundredth before the boundary, then issuing one tick and reading back every affected field. The alarm modes are tested the same way. Counters are preloaded just short of the alarm time, with deliberately mismatched ignored fields, so that the flag's rising edge comes from a single tick.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef struct packed {
    logic [7:0] hund;
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] dayYear;
    logic [7:0] wdayMonth;
  } cal_cnt_t;

  typedef struct packed {
    logic       advance;
    logic       mode12;
    logic       wrHund;
    logic       wrSec;
    logic       wrMin;
    logic       wrHour;
    logic       wrDay;
    logic       wrMonth;
    logic [7:0] data;
  } cal_strb_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [5:0] lastDay(input logic [4:0] month, input logic [1:0] year);
    case (month)
      5'h02:                      return (year == 2'd0) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cal_strb_t strb,
  output cal_cnt_t  cnt
);

  cal_cnt_t nxt;
  logic     dayStep;
  logic     monthStep;
  logic     anyWr;
  logic [7:0] hourInc12;

  assign anyWr = strb.wrHund | strb.wrSec | strb.wrMin |
                 strb.wrHour | strb.wrDay | strb.wrMonth;
  assign hourInc12 = bcdInc({3'b000, cnt.hour[4:0]});

  always_comb begin
    nxt       = cnt;
    dayStep   = 1'b0;
    monthStep = 1'b0;
    if (strb.advance) begin
      if (cnt.hund != 8'h99) nxt.hund = bcdInc(cnt.hund);
      else begin
        nxt.hund = 8'h00;
        if (cnt.sec != 8'h59) nxt.sec = bcdInc(cnt.sec);
        else begin
          nxt.sec = 8'h00;
          if (cnt.min != 8'h59) nxt.min = bcdInc(cnt.min);
          else begin
            nxt.min = 8'h00;
            if (strb.mode12) begin
              if (cnt.hour[4:0] == 5'h12) nxt.hour = {1'b0, cnt.hour[6], 6'h01};
              else if (cnt.hour[4:0] == 5'h11) begin
                nxt.hour = {1'b0, ~cnt.hour[6], 6'h12};
                dayStep  = cnt.hour[6];
              end else nxt.hour = {1'b0, cnt.hour[6], 1'b0, hourInc12[4:0]};
            end else begin
              if (cnt.hour == 8'h23) begin
                nxt.hour = 8'h00;
                dayStep  = 1'b1;
              end else nxt.hour = bcdInc(cnt.hour);
            end
          end
        end
      end
    end
    if (dayStep) begin
      nxt.wdayMonth[7:5] = (cnt.wdayMonth[7:5] >= 3'd6) ? 3'd0 : cnt.wdayMonth[7:5] + 3'd1;
      if (cnt.dayYear[5:0] == lastDay(cnt.wdayMonth[4:0], cnt.dayYear[7:6])) begin
        nxt.dayYear[5:0] = 6'h01;
        monthStep = 1'b1;
      end else nxt.dayYear[5:0] = 6'(bcdInc({2'b00, cnt.dayYear[5:0]}));
    end
    if (monthStep) begin
      if (cnt.wdayMonth[4:0] == 5'h12) begin
        nxt.wdayMonth[4:0] = 5'h01;
        nxt.dayYear[7:6]   = cnt.dayYear[7:6] + 2'd1;
      end else nxt.wdayMonth[4:0] = 5'(bcdInc({3'b000, cnt.wdayMonth[4:0]}));
    end
    if (strb.wrHund)  nxt.hund      = strb.data;
    if (strb.wrSec)   nxt.sec       = strb.data;
    if (strb.wrMin)   nxt.min       = strb.data;
    if (strb.wrHour)  nxt.hour      = strb.data;
    if (strb.wrDay)   nxt.dayYear   = strb.data;
    if (strb.wrMonth) nxt.wdayMonth = strb.data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt.hund      <= 8'h00;
      cnt.sec       <= 8'h00;
      cnt.min       <= 8'h00;
      cnt.hour      <= 8'h00;
      cnt.dayYear   <= 8'h01;
      cnt.wdayMonth <= 8'h01;
    end else begin
      cnt <= nxt;
    end
  end

  // R2: a tick at 99 hundredths wraps them to 00
  a_r2_hund_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.advance && !anyWr && cnt.hund == 8'h99) |=> (cnt.hund == 8'h00));

  // R7: with no advance and no write, nothing moves
  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.advance && !anyWr) |=> $stable(cnt));

  // R8: a write wins over a tick in the same cycle
  a_r8_wr_priority: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrHund |=> (cnt.hund == $past(strb.data)));

endmodule

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  cal_cnt_t          cnt,
  output cal_strb_t         strb,
  output logic [7:0]        rdData,
  output logic              alarmFlag
);

  localparam int NUM_ALARM = 7;
  localparam int ALM_BASE  = 8;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_HUND  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SEC   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MIN   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_HOUR  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_DAY   = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_MONTH = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(ALM_BASE + NUM_ALARM);

  logic [3:0] ctrlReg;
  logic [7:0] almReg [NUM_ALARM];
  logic       stopBit, mode12;
  logic [1:0] almMode;
  logic       timeEq, dateEq, wdayEn, match, matchPrev, clrWr;

  assign stopBit = ctrlReg[0];
  assign mode12  = ctrlReg[1];
  assign almMode = ctrlReg[3:2];

  always_ff @(posedge clk) begin
    if (!rst_n) ctrlReg <= 4'h0;
    else if (wrEn && addr == A_CTRL) ctrlReg <= wrData[3:0];
  end

  for (genvar i = 0; i < NUM_ALARM; i++) begin : g_alm
    always_ff @(posedge clk) begin
      if (!rst_n) almReg[i] <= 8'h00;
      else if (wrEn && addr == ADDR_W'(ALM_BASE + i)) almReg[i] <= wrData;
    end
  end

  always_comb begin
    strb.advance = tick & ~stopBit;
    strb.mode12  = mode12;
    strb.wrHund  = wrEn && addr == A_HUND;
    strb.wrSec   = wrEn && addr == A_SEC;
    strb.wrMin   = wrEn && addr == A_MIN;
    strb.wrHour  = wrEn && addr == A_HOUR;
    strb.wrDay   = wrEn && addr == A_DAY;
    strb.wrMonth = wrEn && addr == A_MONTH;
    strb.data    = wrData;
  end

  assign timeEq = (cnt.hund == almReg[0]) && (cnt.sec == almReg[1]) &&
                  (cnt.min == almReg[2]) && (cnt.hour == almReg[3]);
  assign dateEq = (cnt.dayYear[5:0] == almReg[4][5:0]) &&
                  (cnt.wdayMonth[4:0] == almReg[5][4:0]);
  assign wdayEn = almReg[6][cnt.wdayMonth[7:5]];

  always_comb begin
    case (almMode)
      2'b01:   match = timeEq;
      2'b10:   match = timeEq & wdayEn;
      2'b11:   match = timeEq & dateEq;
      default: match = 1'b0;
    endcase
  end

  assign clrWr = wrEn && addr == A_FLAG && !wrData[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      matchPrev <= 1'b0;
      alarmFlag <= 1'b0;
    end else begin
      matchPrev <= match;
      if (match && !matchPrev) alarmFlag <= 1'b1;
      else if (clrWr)          alarmFlag <= 1'b0;
    end
  end

  always_comb begin
    rdData = 8'h00;
    case (addr)
      A_CTRL:  rdData = {4'h0, ctrlReg};
      A_HUND:  rdData = cnt.hund;
      A_SEC:   rdData = cnt.sec;
      A_MIN:   rdData = cnt.min;
      A_HOUR:  rdData = cnt.hour;
      A_DAY:   rdData = cnt.dayYear;
      A_MONTH: rdData = cnt.wdayMonth;
      A_FLAG:  rdData = {7'h00, alarmFlag};
      default: begin
        for (int i = 0; i < NUM_ALARM; i++)
          if (addr == ADDR_W'(ALM_BASE + i)) rdData = almReg[i];
      end
    endcase
  end

  // R12: the flag holds until a clearing write
  a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alarmFlag && !clrWr) |=> alarmFlag);

  // R12: mode 00 never raises the flag
  a_r12_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
    (almMode == 2'b00 && !alarmFlag) |=> !alarmFlag);

endmodule

// File: rtl/rtc_cal_top.sv
module rtc_cal_top
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              alarmFlag
);

  cal_strb_t strb;
  cal_cnt_t  cnt;

  rtc_cal_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .cnt(cnt), .strb(strb), .rdData(rdData),
    .alarmFlag(alarmFlag)
  );

  rtc_cal_datapath i_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .cnt(cnt)
  );

endmodule

// File: tb/test_rtc_cal_top.sv
module test_rtc_cal_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       alarmFlag;
  int         checks = 0;
  int         errors = 0;
  int         cycles = 0;

  rtc_cal_top i_rtc_cal_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .alarmFlag(alarmFlag)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act hung exp finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s addr %0d: act %h exp %h", req, a, rdData, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic setAll(input logic [7:0] h, input logic [7:0] s, input logic [7:0] m,
                        input logic [7:0] hr, input logic [7:0] d, input logic [7:0] wm);
    wr(4'd1, h); wr(4'd2, s); wr(4'd3, m); wr(4'd4, hr); wr(4'd5, d); wr(4'd6, wm);
  endtask

  task automatic t_reset();
    chk("R1", 4'd0, 8'h00); chk("R1", 4'd1, 8'h00); chk("R1", 4'd2, 8'h00);
    chk("R1", 4'd3, 8'h00); chk("R1", 4'd4, 8'h00); chk("R1", 4'd5, 8'h01);
    chk("R1", 4'd6, 8'h01); chk("R1", 4'd15, 8'h00);
  endtask

  task automatic t_time_carry();
    setAll(8'h99, 8'h59, 8'h59, 8'h05, 8'h10, 8'h21);
    pulse();
    chk("R2", 4'd1, 8'h00); chk("R2", 4'd2, 8'h00); chk("R2", 4'd3, 8'h00);
    chk("R2", 4'd4, 8'h06);
    setAll(8'h39, 8'h09, 8'h00, 8'h05, 8'h10, 8'h21);
    pulse();
    chk("R2", 4'd1, 8'h40); chk("R2", 4'd2, 8'h09);
  endtask

  task automatic t_hours24();
    setAll(8'h99, 8'h59, 8'h59, 8'h23, 8'h05, 8'h21);
    pulse();
    chk("R3", 4'd4, 8'h00); chk("R3", 4'd5, 8'h06); chk("R6", 4'd6, 8'h41);
  endtask

  task automatic t_hours12();
    wr(4'd0, 8'h02);
    setAll(8'h99, 8'h59, 8'h59, 8'h11, 8'h05, 8'h21);
    pulse();
    chk("R4", 4'd4, 8'h52); chk("R4", 4'd5, 8'h05);
    wr(4'd4, 8'h51);
    wr(4'd1, 8'h99); wr(4'd2, 8'h59); wr(4'd3, 8'h59);
    pulse();
    chk("R4", 4'd4, 8'h12); chk("R4", 4'd5, 8'h06);
    wr(4'd4, 8'h12);
    wr(4'd1, 8'h99); wr(4'd2, 8'h59); wr(4'd3, 8'h59);
    pulse();
    chk("R4", 4'd4, 8'h01);
    wr(4'd0, 8'h00);
  endtask

  task automatic t_months();
    setAll(8'h99, 8'h59, 8'h59, 8'h23, 8'h28, 8'h02);
    pulse();
    chk("R5", 4'd5, 8'h29); chk("R5", 4'd6, 8'h22);
    setAll(8'h99, 8'h59, 8'h59, 8'h23, 8'h68, 8'h02);
    pulse();
    chk("R5", 4'd5, 8'h41); chk("R5", 4'd6, 8'h23);
    setAll(8'h99, 8'h59, 8'h59, 8'h23, 8'h70, 8'h04);
    pulse();
    chk("R5", 4'd5, 8'h41); chk("R5", 4'd6, 8'h25);
    setAll(8'h99, 8'h59, 8'h59, 8'h23, 8'h30, 8'h01);
    pulse();
    chk("R5", 4'd5, 8'h31); chk("R5", 4'd6, 8'h21);
  endtask

  task automatic t_year_wrap();
    setAll(8'h99, 8'h59, 8'h59, 8'h23, 8'hF1, 8'hD2);
    pulse();
    chk("R6", 4'd5, 8'h01); chk("R6", 4'd6, 8'h01);
  endtask

  task automatic t_stop();
    setAll(8'h42, 8'h10, 8'h00, 8'h00, 8'h01, 8'h01);
    wr(4'd0, 8'h01);
    pulse(); pulse();
    chk("R7", 4'd1, 8'h42);
    wr(4'd1, 8'h77);
    chk("R7", 4'd1, 8'h77);
    wr(4'd0, 8'h00);
    pulse();
    chk("R7", 4'd1, 8'h78);
  endtask

  task automatic t_wr_prio();
    @(negedge clk);
    wrEn = 1'b1; tick = 1'b1; addr = 4'd1; wrData = 8'h55;
    @(negedge clk);
    wrEn = 1'b0; tick = 1'b0;
    chk("R8", 4'd1, 8'h55);
    chk("R8", 4'd9, 8'h00);
  endtask

  // counters one hundredth before 10:00:00.00, then a tick
  task automatic armTick(input string req, input logic [7:0] d, input logic [7:0] wm,
                         input logic [7:0] exp);
    setAll(8'h99, 8'h59, 8'h59, 8'h09, d, wm);
    wr(4'd15, 8'h00);
    pulse();
    @(negedge clk); @(negedge clk);
    chk(req, 4'd15, exp);
  endtask

  task automatic t_alarms();
    wr(4'd8, 8'h00); wr(4'd9, 8'h00); wr(4'd10, 8'h00); wr(4'd11, 8'h10);
    wr(4'd12, 8'h15); wr(4'd13, 8'h07); wr(4'd14, 8'h08);
    chk("R12", 4'd15, 8'h00);
    armTick("R12", 8'h95, 8'h67, 8'h00);
    wr(4'd0, 8'h04);
    armTick("R9", 8'h22, 8'h4B, 8'h01);
    pulse(); pulse();
    chk("R12", 4'd15, 8'h01);
    wr(4'd15, 8'h00);
    chk("R12", 4'd15, 8'h00);
    wr(4'd0, 8'h0C);
    armTick("R10", 8'h95, 8'h68, 8'h00);
    armTick("R10", 8'h95, 8'h67, 8'h01);
    wr(4'd0, 8'h08);
    armTick("R11", 8'h95, 8'h87, 8'h00);
    armTick("R11", 8'h95, 8'h67, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_time_carry();
    t_hours24();
    t_hours12();
    t_months();
    t_year_wrap();
    t_stop();
    t_wr_prio();
    t_alarms();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule